// File: doc/BRIEF.md
# Dual-Output Logic Cluster

The block models a programmable logic cluster of ten logic elements. Each element has a 4-input lookup table (LUT) and one D flip-flop. The flip-flop always registers the LUT result. Both the LUT value and the flip-flop value leave the element at the same time, because there is no output-select multiplexer. A full crossbar feeds every element input. Each element input may take any of the 22 cluster inputs or any of the 20 element outputs. A downstream element can therefore use the combinational and the registered copy of one signal together.

The LUT masks and crossbar selects are loaded through a serial configuration chain. While the chain is being loaded, the flip-flops are held cleared. A combinational loop through LUT outputs and the crossbar is a user error. The block still gives a defined value in that case: it is whatever the fixed number of settling passes yields.

Top module: `dual_out_cluster`

## Requirements
- R1: A synchronous active-high `rst` clears every flip-flop and the whole configuration image. After a reset edge, all 20 bits of `dout` read 0.
- R2: While `cfg_en` is high, each rising edge shifts `cfg_din` into a 400-bit image. The first bit shifted lands at image bit 0 after 400 shifts. Element e owns image bits 40e to 40e+39. Its mask sits at 40e+0..15. The 6-bit select of its input k sits at 40e+16+6k, least significant bit first.
- R3: The LUT output of an element equals its mask bit at index {in3,in2,in1,in0}, with input 0 as the least significant address bit.
- R4: Select value s picks the source as follows. Values 0..21 take `din[s]`. Value 22+2e takes the LUT output of element e. Value 23+2e takes the flip-flop of element e. Values 42..63 give constant 0.
- R5: With `rst` and `cfg_en` low, each rising edge loads every flip-flop with its element's current LUT output.
- R6: While `cfg_en` is high at a rising edge, every flip-flop is cleared.
- R7: `dout[2e]` is the LUT output of element e and `dout[2e+1]` is its flip-flop. Both are valid in the same cycle.
- R8: A loop-free chain of up to ten elements settles within one cycle. An element may read both the LUT and the flip-flop of another element at once.
- R9: With `cfg_en` low, the configuration is held. With the inputs and flip-flops unchanged, the LUT outputs do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cluster clock, shared by all flip-flops |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable; holds the flip-flops clear |
| cfg_din | input | 1 | Serial configuration data |
| din | input | 22 | General cluster inputs |
| dout | output | 20 | Element outputs: even bits LUT, odd bits flip-flop |

## Verification
Three configurations are driven with random input words. The first has every element reading cluster inputs through AND, OR, XOR and selector masks, with two selects out of range. It separates errors in mask address order, select decoding and constant-zero handling. The second is a ten-deep XOR chain in which each element reads both outputs of its predecessor. It exposes settling that is too short and swapped LUT and flip-flop sources. The third uses a flip-flop feeding back into its own LUT as a toggle, and mid-run reloads and resets confirm that the flip-flops are cleared.

// File: rtl/dual_out_cluster.sv
module dual_out_cluster #(
  parameter int N_ELEM = 10,
  parameter int N_IN   = 22,
  parameter int K      = 4,
  parameter int SEL_W  = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_en,
  input  logic                cfg_din,
  input  logic [N_IN-1:0]     din,
  output logic [2*N_ELEM-1:0] dout
);
  localparam int MASK_W = 1 << K;
  localparam int ELEM_W = MASK_W + K * SEL_W;
  localparam int CFG_W  = N_ELEM * ELEM_W;
  localparam int N_SRC  = N_IN + 2 * N_ELEM;
  localparam int N_SEL  = 1 << SEL_W;

  logic [CFG_W-1:0]  cfg;
  logic [N_ELEM-1:0] ffq;
  logic [N_ELEM-1:0] lut_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg <= '0;
    else if (cfg_en) cfg <= {cfg_din, cfg[CFG_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_en) ffq <= '0;
    else               ffq <= lut_q;
  end

  always_comb begin : settle
    logic [N_ELEM-1:0] cur;
    logic [N_ELEM-1:0] nxt;
    logic [N_SEL-1:0]  srcx;
    logic [MASK_W-1:0] m;
    logic [SEL_W-1:0]  s;
    logic [K-1:0]      a;
    cur = '0;
    for (int p = 0; p < N_ELEM; p++) begin
      srcx = '0;
      srcx[N_IN-1:0] = din;
      for (int e = 0; e < N_ELEM; e++) begin
        srcx[N_IN + 2*e]     = cur[e];
        srcx[N_IN + 2*e + 1] = ffq[e];
      end
      for (int e = 0; e < N_ELEM; e++) begin
        m = cfg[e*ELEM_W +: MASK_W];
        for (int k = 0; k < K; k++) begin
          s    = cfg[e*ELEM_W + MASK_W + k*SEL_W +: SEL_W];
          a[k] = srcx[s];
        end
        nxt[e] = m[a];
      end
      cur = nxt;
    end
    lut_q = cur;
  end

  for (genvar g = 0; g < N_ELEM; g++) begin : g_out
    assign dout[2*g]     = lut_q[g];
    assign dout[2*g + 1] = ffq[g];
  end

  logic unused_ok;
  assign unused_ok = (N_SRC > N_SEL);
endmodule

// File: rtl/dual_out_cluster_chk.sv
module dual_out_cluster_chk #(
  parameter int N_ELEM = 10,
  parameter int N_IN   = 22
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_en,
  input logic [N_IN-1:0]     din,
  input logic [2*N_ELEM-1:0] dout
);
  logic [N_ELEM-1:0] lq, fq;
  for (genvar g = 0; g < N_ELEM; g++) begin : g_split
    assign lq[g] = dout[2*g];
    assign fq[g] = dout[2*g + 1];
  end

  // R1
  rst_clears_chk: assert property (@(posedge clk) rst |=> (fq == '0));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (fq == '0));

  // R5
  ff_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en) |=> (fq == $past(lq)));

  // R9
  lut_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !$past(cfg_en) && !$past(rst) && $stable(din) && $stable(fq))
      |-> $stable(lq));
endmodule

bind dual_out_cluster dual_out_cluster_chk #(.N_ELEM(N_ELEM), .N_IN(N_IN)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .din(din), .dout(dout)
);

// File: tb/tb_dual_out_cluster.sv
`timescale 1ns/1ps
module tb_dual_out_cluster;
  localparam int NE = 10;
  localparam int NI = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic cfg_din = 1'b0;
  logic [NI-1:0] din = '0;
  logic [2*NE-1:0] dout;

  dual_out_cluster dut (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
                        .din(din), .dout(dout));

  always #4 clk = ~clk;

  logic [15:0] mask_m [NE];
  logic [5:0]  sel_m  [NE][4];
  logic [NE-1:0] lutm, ffm;
  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic srcbit(input int s);
    if (s < NI) return din[s];
    if (s < NI + 2*NE) return ((s - NI) % 2 == 1) ? ffm[(s-NI)/2] : lutm[(s-NI)/2];
    return 1'b0;
  endfunction

  task automatic model_eval();
    logic [NE-1:0] nv;
    int idx;
    lutm = '0;
    for (int it = 0; it < 64; it++) begin
      for (int e = 0; e < NE; e++) begin
        idx = 0;
        for (int k = 0; k < 4; k++) if (srcbit(int'(sel_m[e][k]))) idx += (1 << k);
        nv[e] = mask_m[e][idx];
      end
      if (nv == lutm) break;
      lutm = nv;
    end
  endtask

  function automatic logic [2*NE-1:0] expected();
    logic [2*NE-1:0] r;
    for (int e = 0; e < NE; e++) begin
      r[2*e] = lutm[e];
      r[2*e+1] = ffm[e];
    end
    return r;
  endfunction

  function automatic logic [NE-1:0] odd_bits(input logic [2*NE-1:0] v);
    logic [NE-1:0] r;
    for (int e = 0; e < NE; e++) r[e] = v[2*e+1];
    return r;
  endfunction

  function automatic logic [NE-1:0] even_bits(input logic [2*NE-1:0] v);
    logic [NE-1:0] r;
    for (int e = 0; e < NE; e++) r[e] = v[2*e];
    return r;
  endfunction

  // called at a negedge, returns at a negedge
  task automatic load_cfg();
    logic [399:0] img;
    for (int e = 0; e < NE; e++) begin
      for (int b = 0; b < 16; b++) img[e*40+b] = mask_m[e][b];
      for (int k = 0; k < 4; k++)
        for (int b = 0; b < 6; b++) img[e*40+16+k*6+b] = sel_m[e][k][b];
    end
    for (int i = 0; i < 400; i++) begin
      if (i == 5 || i == 399)
        chk(odd_bits(dout) == '0, "R6 ffs held clear during load", 32'(odd_bits(dout)), 0);
      cfg_en = 1'b1;
      cfg_din = img[i];
      din = NI'($urandom);
      @(posedge clk); @(negedge clk);
    end
    ffm = '0;
  endtask

  task automatic run_cycle(input string tag);
    logic [NE-1:0] nxt;
    cfg_en = 1'b0;
    din = NI'($urandom);
    #1;
    model_eval();
    chk(even_bits(dout) == lutm, tag, 32'(even_bits(dout)), 32'(lutm));
    chk(odd_bits(dout) == ffm, "R5 R7 flip-flop outputs", 32'(odd_bits(dout)), 32'(ffm));
    nxt = lutm;
    @(posedge clk);
    ffm = nxt;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    ffm = '0;
    chk(dout == '0, "R1 outputs zero after reset", 32'(dout), 0);
  endtask

  task automatic cfg_a();
    for (int e = 0; e < NE; e++) begin
      for (int k = 0; k < 4; k++) sel_m[e][k] = 6'((e*2 + k) % NI);
      case (e % 4)
        0: mask_m[e] = 16'h8000;
        1: mask_m[e] = 16'hFFFE;
        2: mask_m[e] = 16'h6996;
        default: mask_m[e] = 16'hCACA;
      endcase
    end
    sel_m[8][0] = 6'd42; mask_m[8] = 16'hAAAA;
    sel_m[9][3] = 6'd63; mask_m[9] = 16'hFF00;
  endtask

  task automatic cfg_b();
    for (int k = 0; k < 4; k++) sel_m[0][k] = 6'(k);
    mask_m[0] = 16'h6996;
    for (int e = 1; e < NE; e++) begin
      sel_m[e][0] = 6'(NI + 2*(e-1));
      sel_m[e][1] = 6'(NI + 2*(e-1) + 1);
      sel_m[e][2] = 6'(e + 5);
      sel_m[e][3] = 6'd21;
      mask_m[e] = 16'h6996;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NE; e++) begin
      mask_m[e] = '0;
      for (int k = 0; k < 4; k++) sel_m[e][k] = '0;
    end
    ffm = '0; lutm = '0;
    @(negedge clk);
    do_reset();

    cfg_a();
    load_cfg();
    for (int i = 0; i < 40; i++) run_cycle("R2 R3 R4 R7 direct-input LUTs");
    chk(dout[16] == 1'b0 && dout[18] == 1'b0, "R4 out-of-range select gives 0",
        32'({dout[18], dout[16]}), 0);

    cfg_b();
    load_cfg();
    for (int i = 0; i < 40; i++) run_cycle("R8 ten-deep chain with both outputs");

    cfg_a();
    sel_m[0][0] = 6'(NI + 1); sel_m[0][1] = 6'd0; mask_m[0] = 16'h6666;
    load_cfg();
    for (int i = 0; i < 40; i++) run_cycle("R9 R3 toggle feedback via flip-flop");

    do_reset();
    for (int e = 0; e < NE; e++) begin
      mask_m[e] = '0;
      for (int k = 0; k < 4; k++) sel_m[e][k] = '0;
    end
    for (int i = 0; i < 4; i++) run_cycle("R1 config cleared by reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule